// File: doc/BRIEF.md
# Device Control and Status Register Pair

This block holds the device control register and the device status register of a root port's configuration space. Each is 16 bits wide and both share one configuration dword. A simple configuration port addresses that dword with a dword address and four byte enables. Reads are combinational. Writes land on the rising clock edge.

Four error detectors feed the block with one-cycle pulses, one for each class:

- correctable
- non-fatal
- fatal
- unsupported request

Every detection is logged in a sticky status flag, whatever the control register says. Software clears a flag by writing 1 to it. The control enables decide only whether a detection is passed on as an internal report pulse. A root port raises no outgoing error message, so the report pulses are the block's only reaction to an error.

A level input for pending transactions is shown read-only in the status register.

Top module: `devctl_status_slice`

## Requirements
- R1: After reset the dword at byte offset A8h reads 00000000h (with the pending input low), and all report outputs are 0.
- R2: Control bits 3:0 (dword bits 3:0) are read/write reporting enables. Bit 0 is correctable, bit 1 non-fatal, bit 2 fatal and bit 3 unsupported request. They are written through byte enable 0.
- R3: The max payload size field, control bits 7:5, always reads 000b. A write of any value, including a reserved one, leaves it at 000b. Control bit 4 and bits 15:8 read 0.
- R4: A detection pulse on class i (det[0] correctable, det[1] non-fatal, det[2] fatal, det[3] unsupported) sets status flag i (dword bit 16+i). This happens whether or not enable i is set.
- R5: Writing 1 to a status flag through byte enable 2 clears it. Writing 0 leaves it unchanged.
- R6: When a detection and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R7: Status bit 5 (dword bit 21) follows the pending-transactions input. Writes do not change it. Status bit 4 and bits 15:6 read 0.
- R8: rpt[i] is high for exactly the one cycle after a det[i] pulse, if enable i was set at that pulse. Otherwise rpt[i] stays 0.
- R9: Each byte enable gates only its own byte. A write with be[0] low leaves the enables unchanged. A write with be[2] low clears no flag.
- R10: Any other dword address reads 0, and writes to it change nothing in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_addr | input | 10 | configuration dword address (byte address bits 11:2) |
| cfg_wr | input | 1 | write strobe |
| cfg_be | input | 4 | byte enables for the write |
| cfg_wdata | input | 32 | write data |
| cfg_rdata | output | 32 | read data for cfg_addr |
| det | input | 4 | error detection pulses, one per class |
| txn_pending | input | 1 | transactions still pending |
| rpt | output | 4 | internal report pulses, one per class |

## Verification
Detections are driven in three ways. With enables off, the test shows that logging does not depend on reporting. With enables on, it shows the one-cycle report pulse and its timing. Detections on mixed classes show that each class keeps its own bit position.

Clears are driven in three ways as well: alone, together with a detection on the same flag, and with the status byte enable low. These separate a true write-1-clear from a plain overwrite and from a collision that loses a detection. Control writes carry every reserved payload value and reserved-bit patterns, at the block's own address and at a foreign one.

// File: rtl/devctl_status_slice.sv
module devctl_status_slice #(
  parameter int                   ADDR_W  = 10,
  parameter logic [ADDR_W-1:0]    SLOT_DW = 10'h02A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [3:0]        det,
  input  logic              txn_pending,
  output logic [3:0]        rpt
);
  localparam logic [2:0] MPS_128 = 3'b000;

  logic [3:0] en;
  logic [3:0] flags;
  logic       hit;
  logic [3:0] clr;
  logic [15:0] ctl_view, sts_view;
  logic       unused_bits;

  assign hit = (cfg_addr == SLOT_DW);
  assign clr = (cfg_wr && hit && cfg_be[2]) ? cfg_wdata[19:16] : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      flags <= '0;
      rpt   <= '0;
    end else begin
      if (cfg_wr && hit && cfg_be[0]) en <= cfg_wdata[3:0];
      flags <= (flags & ~clr) | det;
      rpt   <= det & en;
    end
  end

  assign ctl_view  = {8'h00, MPS_128, 1'b0, en};
  assign sts_view  = {10'h000, txn_pending, 1'b0, flags};
  assign cfg_rdata = hit ? {sts_view, ctl_view} : 32'h0;

  assign unused_bits = ^{cfg_wdata[31:20], cfg_wdata[15:4], cfg_be[3], cfg_be[1]};
endmodule

// File: rtl/devctl_status_chk.sv
module devctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] det,
  input logic [3:0] rpt,
  input logic [3:0] en,
  input logic [3:0] flags
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (flags == 4'h0 && en == 4'h0 && rpt == 4'h0));
  // R4
  det_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(det)) |-> (($past(det) & ~flags) == 4'h0));
  // R5
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(det)) == 4'h0));
  // R8
  rpt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rpt & ~$past(det)) == 4'h0));
  // R8
  rpt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rpt & ~$past(en)) == 4'h0));
endmodule

bind devctl_status_slice devctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det(det), .rpt(rpt), .en(en), .flags(flags)
);

// File: tb/tb_devctl_status_slice.sv
module tb_devctl_status_slice;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] SLOT = 10'h02A;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  cfg_addr = SLOT;
  logic        cfg_wr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [3:0]  det = 0;
  logic        txn_pending = 0;
  logic [3:0]  rpt;
  int total = 0, bad = 0;
  bit finished = 0;

  devctl_status_slice dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1;
    cyc();
    cfg_wr = 0; cfg_addr = SLOT;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    cfg_addr = a; #1 d = cfg_rdata; cfg_addr = SLOT;
  endtask

  task automatic pulse(input logic [3:0] p);
    det = p; cyc(); det = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(SLOT, d);
    check("R1 dword", d, 32'h0);
    check("R1 rpt", {28'h0, rpt}, 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(SLOT, 4'b0001, 32'h0000_0005);
    rd(SLOT, d); check("R2 en 0101", d, 32'h5);
    wr(SLOT, 4'b0001, 32'h0000_000A);
    rd(SLOT, d); check("R2 en 1010", d, 32'hA);
    wr(SLOT, 4'b0001, 32'h0);
  endtask

  task automatic t_mps();
    logic [31:0] d;
    for (int v = 0; v < 8; v++) begin
      wr(SLOT, 4'b0011, 32'h0000_FF10 | (v << 5) | 32'h3);
      rd(SLOT, d); check("R3 mps/reserved", d, 32'h3);
    end
    wr(SLOT, 4'b0001, 32'h0);
  endtask

  task automatic t_log_disabled();
    logic [31:0] d;
    pulse(4'b0101);
    check("R8 no rpt when disabled", {28'h0, rpt}, 32'h0);
    rd(SLOT, d); check("R4 logged w/o enable", d, 32'h0005_0000);
    pulse(4'b1010);
    rd(SLOT, d); check("R4 all classes", d, 32'h000F_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(SLOT, 4'b0100, 32'h0000_0000);
    rd(SLOT, d); check("R5 write 0 keeps", d, 32'h000F_0000);
    wr(SLOT, 4'b0100, 32'h0006_0000);
    rd(SLOT, d); check("R5 clear 1,2", d, 32'h0009_0000);
    wr(SLOT, 4'b0100, 32'h0009_0000);
    rd(SLOT, d); check("R5 clear rest", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pulse(4'b0100);
    det = 4'b0100;
    wr(SLOT, 4'b0100, 32'h0004_0000);
    det = 0;
    rd(SLOT, d); check("R6 set wins", d, 32'h0004_0000);
    wr(SLOT, 4'b0100, 32'h0004_0000);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    txn_pending = 1; rd(SLOT, d); check("R7 pending high", d, 32'h0020_0000);
    wr(SLOT, 4'b1100, 32'hFFE0_0000);
    rd(SLOT, d); check("R7 write ignored", d, 32'h0020_0000);
    txn_pending = 0; rd(SLOT, d); check("R7 pending low", d, 32'h0);
  endtask

  task automatic t_report();
    wr(SLOT, 4'b0001, 32'h0000_0009);
    det = 4'b1011; cyc(); det = 0;
    check("R8 rpt gated pulse", {28'h0, rpt}, 32'h9);
    cyc();
    check("R8 rpt one cycle", {28'h0, rpt}, 32'h0);
    wr(SLOT, 4'b0100, 32'h000F_0000);
    wr(SLOT, 4'b0001, 32'h0);
  endtask

  task automatic t_byte_en();
    logic [31:0] d;
    wr(SLOT, 4'b1110, 32'h000F_000F);
    rd(SLOT, d); check("R9 be0 low keeps en", d, 32'h0);
    pulse(4'b0011);
    wr(SLOT, 4'b1011, 32'h000F_0000);
    rd(SLOT, d); check("R9 be2 low keeps flags", d, 32'h0003_0000);
    wr(SLOT, 4'b0100, 32'h0003_0000);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    pulse(4'b1000);
    rd(10'h02B, d); check("R10 foreign read", d, 32'h0);
    wr(10'h029, 4'b1111, 32'hFFFF_FFFF);
    rd(SLOT, d); check("R10 foreign write", d, 32'h0008_0000);
    wr(SLOT, 4'b0100, 32'h0008_0000);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_enables();
    t_mps();
    t_log_disabled();
    t_w1c();
    t_collision();
    t_pending();
    t_report();
    t_byte_en();
    t_addr();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule